// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block maps a CPU physical address onto one of several DRAM chip-select windows. Each window is programmed over a 32-bit write-only register port. Each lookup returns, one clock later, three things. The first is a hit flag. The second is the chip-select number to use. The third is an 8-bit bus attribute. The attribute carries a one-cold code of the window number and an optional hardware-coherency bit. A separate flag tells whether the hit window sits below 4 GB. Only such a window can be reached by a master that drives 32 address bits.

A parameter selects a compact variant with two windows. In that variant each window is one packed register holding an enable, a base in 8 MB steps and a logarithmic size. The compact variant drives a zero attribute and uses the window number as the chip-select number. The DRAM controller and any read-back of the windows are outside this block.

Top module: `dcsw_decoder`

## Requirements
- R1: While reset is asserted and after it is released, every window is disabled, so every lookup misses until a window is written.
- R2: In the default variant, window n (0 to 3) has its base register at byte offset 8n and its size register at 8n+4. A write to an offset of 32 or more, or to an offset whose two low bits are not zero, changes no window.
- R3: In the size register, bit 0 enables the window, bits 4:2 give the chip-select number, and bits 31:24 give S. The window spans (S+1) × 16 MB from its base.
- R4: In the base register, bits 31:24 become address bits 31:24 of the window base and bits 3:0 become address bits 35:32. The other base address bits are zero.
- R5: The outputs are registered. A lookup address presented before clock edge k is answered after edge k, using the window settings in force before that edge. On a hit in the default variant, cs_o carries the chip-select number of the window.
- R6: In the default variant, a hit in window i gives attr_o[3:0] = 4'hF with bit i cleared. attr_o[4] copies coherent_i as sampled with the address, and attr_o[7:5] is zero.
- R7: In the default variant, low_ok_o is 1 on a hit only if base bits 35:32 of the hit window are all zero.
- R8: When several enabled windows contain the address, the lowest-numbered one decides the outputs.
- R9: On a miss, hit_o, cs_o, attr_o and low_ok_o are all zero.
- R10: In the compact variant, window n (0 or 1) uses one register at byte offset 16n. Writes to other offsets are ignored. Bit 0 enables the window and bits 31:23 give address bits 31:23 of the base. The size is 1 MB shifted left by (F − 4), where F is bits 19:16.
- R11: In the compact variant, a hit gives attr_o = 0, cs_o equal to the window number, and low_ok_o = 1.
- R12: In the compact variant, a window whose F field is below 4 never hits, even when its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register byte offset |
| wr_data_i | input | 32 | Register write data |
| addr_i | input | 36 | Physical address to decode |
| coherent_i | input | 1 | Hardware-coherency enable, sets attribute bit 4 |
| hit_o | output | 1 | Address falls in an enabled window |
| cs_o | output | 3 | Chip-select number of the hit window |
| attr_o | output | 8 | Bus attribute of the hit window |
| low_ok_o | output | 1 | Hit window lies below 4 GB |

## Verification
The bench probes the first and last byte of each window and the first byte past its end. An off-by-one in the (S+1) or shifted-size arithmetic would therefore turn a boundary hit into a miss, or the reverse. It also places windows at the same low address bits but different bits 35:32. A decoder that drops the high base bits would then report a false hit, or keep low_ok_o set for a window above 4 GB. Overlapping windows, with the lower one later disabled, expose a priority encoder that favours the wrong index. Writes to misaligned or out-of-range offsets, and a compact window with F below 4, show whether a decoder writes registers it should not or builds a window with a nonsense size.

// File: rtl/dcsw_pkg.sv
`timescale 1ns/1ps
package dcsw_pkg;
    localparam int ADDR_W  = 36;   // physical address width
    localparam int REG_W   = 32;   // register port width
    localparam int OFF_W   = 8;    // register offset width
    localparam int CS_W    = 3;    // chip-select number width
    localparam int ATTR_W  = 8;    // bus attribute width
    localparam int HI_W    = ADDR_W - REG_W;  // base bits above 4 GB
    localparam int SPAN_W  = 8;    // size field width
    localparam int LO_W    = 9;    // base bits kept below 4 GB

    // One window's decoded configuration, shared by both variants.
    typedef struct packed {
        logic              en;
        logic [CS_W-1:0]   cs;
        logic [SPAN_W-1:0] span;
        logic [HI_W-1:0]   hi;
        logic [LO_W-1:0]   lo;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [CS_W-1:0]   cs;
        logic [ATTR_W-1:0] attr;
        logic              low_ok;
    } dec_out_t;
endpackage

// File: rtl/dcsw_regs.sv
`timescale 1ns/1ps
module dcsw_regs
    import dcsw_pkg::*;
#(
    parameter bit COMPACT = 1'b0,
    parameter int NUM_WIN = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_en_i,
    input  logic [OFF_W-1:0]         wr_addr_i,
    input  logic [REG_W-1:0]         wr_data_i,
    output win_cfg_t [NUM_WIN-1:0]   cfg_o
);
    localparam int STRIDE_LG = COMPACT ? 4 : 3;
    localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int SPAN_OFF  = NUM_WIN << STRIDE_LG;

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             in_range;
    logic             aligned;
    logic [IDX_W-1:0] sel;
    logic             unused_wdata;

    assign in_range     = {1'b0, wr_addr_i} < (OFF_W+1)'(SPAN_OFF);
    assign sel          = wr_addr_i[STRIDE_LG +: IDX_W];
    assign unused_wdata = ^wr_data_i;

    generate
        if (COMPACT) begin : g_align_c
            assign aligned = (wr_addr_i[3:0] == 4'h0);
        end else begin : g_align_n
            assign aligned = (wr_addr_i[1:0] == 2'h0);
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i && in_range && aligned) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (sel == IDX_W'(w)) begin
                    if (COMPACT) begin
                        regs_d.win[w].en   = wr_data_i[0];
                        regs_d.win[w].lo   = wr_data_i[31:23];
                        regs_d.win[w].span = {4'h0, wr_data_i[19:16]};
                    end else if (wr_addr_i[2]) begin
                        regs_d.win[w].en   = wr_data_i[0];
                        regs_d.win[w].cs   = wr_data_i[4:2];
                        regs_d.win[w].span = wr_data_i[31:24];
                    end else begin
                        regs_d.win[w].hi   = wr_data_i[3:0];
                        regs_d.win[w].lo   = {wr_data_i[31:24], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign cfg_o = regs_q.win;

    // Writes outside the window block leave every window untouched (R2, R10).
    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i || !in_range) |=> $stable(regs_q));
endmodule

// File: rtl/dcsw_match.sv
`timescale 1ns/1ps
module dcsw_match
    import dcsw_pkg::*;
#(
    parameter bit COMPACT = 1'b0
) (
    input  win_cfg_t          cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic unused_in;
    assign unused_in = ^{addr_i, cfg_i};

    generate
        if (COMPACT) begin : g_log
            localparam int UNIT_LG = 20;             // 1 MB units
            localparam int UW      = ADDR_W - UNIT_LG + 1;
            logic [UW-1:0] unit_c, base_c, len_c, end_c;
            always_comb begin
                unit_c = {1'b0, addr_i[ADDR_W-1:UNIT_LG]};
                base_c = UW'({cfg_i.lo, 3'b000});
                if (cfg_i.span[3:0] >= 4'd4)
                    len_c = UW'(1) << (cfg_i.span[3:0] - 4'd4);
                else
                    len_c = '0;
                end_c = base_c + len_c;
                hit_o = cfg_i.en && (len_c != '0) &&
                        (unit_c >= base_c) && (unit_c < end_c);
            end
        end else begin : g_lin
            localparam int UNIT_LG = 24;             // 16 MB units
            localparam int UW      = ADDR_W - UNIT_LG + 1;
            logic [UW-1:0] unit_n, base_n, end_n;
            always_comb begin
                unit_n = {1'b0, addr_i[ADDR_W-1:UNIT_LG]};
                base_n = {1'b0, cfg_i.hi, cfg_i.lo[LO_W-1:1]};
                end_n  = base_n + UW'(cfg_i.span) + UW'(1);
                hit_o  = cfg_i.en && (unit_n >= base_n) && (unit_n < end_n);
            end
        end
    endgenerate
endmodule

// File: rtl/dcsw_pick.sv
`timescale 1ns/1ps
module dcsw_pick
    import dcsw_pkg::*;
#(
    parameter bit COMPACT = 1'b0,
    parameter int NUM_WIN = 4
) (
    input  logic [NUM_WIN-1:0]     hits_i,
    input  win_cfg_t [NUM_WIN-1:0] cfg_i,
    input  logic                   coherent_i,
    output dec_out_t               dec_o
);
    logic unused_in;
    assign unused_in = ^{cfg_i, coherent_i};

    // Walk from the top so the lowest-numbered hit is written last.
    always_comb begin
        dec_o = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hits_i[w]) begin
                dec_o.hit = 1'b1;
                if (COMPACT) begin
                    dec_o.cs     = CS_W'(w);
                    dec_o.attr   = '0;
                    dec_o.low_ok = 1'b1;
                end else begin
                    dec_o.cs     = cfg_i[w].cs;
                    dec_o.attr   = {3'b000, coherent_i, ~(4'h1 << w)};
                    dec_o.low_ok = (cfg_i[w].hi == '0);
                end
            end
        end
    end
endmodule

// File: rtl/dcsw_decoder.sv
`timescale 1ns/1ps
module dcsw_decoder
    import dcsw_pkg::*;
#(
    parameter bit COMPACT = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [OFF_W-1:0]  wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              coherent_i,
    output logic              hit_o,
    output logic [CS_W-1:0]   cs_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic              low_ok_o
);
    localparam int NUM_WIN = COMPACT ? 2 : 4;

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hits;
    dec_out_t               dec_d, dec_q;

    dcsw_regs #(.COMPACT(COMPACT), .NUM_WIN(NUM_WIN)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        dcsw_match #(.COMPACT(COMPACT)) u_match (
            .cfg_i  (cfg[g]),
            .addr_i (addr_i),
            .hit_o  (hits[g])
        );
    end

    dcsw_pick #(.COMPACT(COMPACT), .NUM_WIN(NUM_WIN)) u_pick (
        .hits_i     (hits),
        .cfg_i      (cfg),
        .coherent_i (coherent_i),
        .dec_o      (dec_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dec_q <= '0;
        else         dec_q <= dec_d;
    end

    assign hit_o    = dec_q.hit;
    assign cs_o     = dec_q.cs;
    assign attr_o   = dec_q.attr;
    assign low_ok_o = dec_q.low_ok;

    assert_miss_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> (cs_o == '0 && attr_o == '0 && !low_ok_o));

    assert_low_needs_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_ok_o |-> hit_o);

    generate
        if (COMPACT) begin : g_chk_c
            assert_flat_attr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
                hit_o |-> (attr_o == '0 && low_ok_o && cs_o < CS_W'(NUM_WIN)));
        end else begin : g_chk_n
            assert_one_cold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                hit_o |-> ($countones(attr_o[3:0]) == 3 && attr_o[7:5] == 3'b000));
            assert_coh_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (hit_o && $past(rst_ni)) |-> (attr_o[4] == $past(coherent_i)));
        end
    endgenerate
endmodule

// File: tb/dcsw_decoder_tb.sv
`timescale 1ns/1ps
module dcsw_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_n = 1'b0, wr_en_c = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [35:0] addr = '0;
    logic        coh = 1'b0;

    logic       n_hit, n_low, c_hit, c_low;
    logic [2:0] n_cs, c_cs;
    logic [7:0] n_attr, c_attr;

    int checks = 0;
    int fails  = 0;

    logic [31:0] nb [4];
    logic [31:0] ns [4];
    logic [31:0] cm [2];

    always #2 clk = ~clk;   // 250 MHz

    dcsw_decoder #(.COMPACT(1'b0)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_n), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .addr_i(addr), .coherent_i(coh),
        .hit_o(n_hit), .cs_o(n_cs), .attr_o(n_attr), .low_ok_o(n_low));

    dcsw_decoder #(.COMPACT(1'b1)) u_dut_cmp (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_c), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .addr_i(addr), .coherent_i(coh),
        .hit_o(c_hit), .cs_o(c_cs), .attr_o(c_attr), .low_ok_o(c_low));

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: linear windows, lowest index first.
    task automatic model_normal(input logic [35:0] a, input logic c,
                                output logic h, output logic [2:0] cs,
                                output logic [7:0] at, output logic lo);
        longint b, s;
        h = 0; cs = 0; at = 0; lo = 0;
        for (int w = 0; w < 4; w++) begin
            if (!h && ns[w][0]) begin
                b = (longint'(nb[w][3:0]) << 32) | (longint'(nb[w][31:24]) << 24);
                s = (longint'(ns[w][31:24]) + 1) << 24;
                if (longint'(a) >= b && longint'(a) < b + s) begin
                    h  = 1;
                    cs = ns[w][4:2];
                    at = (8'h0F & ~(8'h01 << w)) | (c ? 8'h10 : 8'h00);
                    lo = (nb[w][3:0] == 4'h0);
                end
            end
        end
    endtask

    task automatic model_compact(input logic [35:0] a, output logic h,
                                 output logic [2:0] cs, output logic [7:0] at,
                                 output logic lo);
        longint b, s;
        int f;
        h = 0; cs = 0; at = 0; lo = 0;
        for (int w = 0; w < 2; w++) begin
            f = int'(cm[w][19:16]);
            if (!h && cm[w][0] && f >= 4) begin
                b = longint'(cm[w][31:23]) << 23;
                s = longint'(1) << (20 + f - 4);
                if (longint'(a) >= b && longint'(a) < b + s) begin
                    h = 1; cs = 3'(w); lo = 1;
                end
            end
        end
    endtask

    // One clock: predict from pre-edge state, update model, sample after edge.
    task automatic tick(input string req);
        logic eh, el, ch, cl;
        logic [2:0] ecs, ccs;
        logic [7:0] eat, cat;
        model_normal(addr, coh, eh, ecs, eat, el);
        model_compact(addr, ch, ccs, cat, cl);
        if (wr_en_n && wr_addr < 8'd32 && wr_addr[1:0] == 2'b00) begin
            if (wr_addr[2]) ns[wr_addr[4:3]] = wr_data;
            else            nb[wr_addr[4:3]] = wr_data;
        end
        if (wr_en_c && wr_addr < 8'd32 && wr_addr[3:0] == 4'h0)
            cm[wr_addr[4]] = wr_data;
        @(posedge clk); #1;
        check(req, "hit",      n_hit,  eh);
        check(req, "cs",       n_cs,   ecs);
        check(req, "attr",     n_attr, eat);
        check(req, "low_ok",   n_low,  el);
        check(req, "c_hit",    c_hit,  ch);
        check(req, "c_cs",     c_cs,   ccs);
        check(req, "c_attr",   c_attr, cat);
        check(req, "c_low_ok", c_low,  cl);
        wr_en_n = 0;
        wr_en_c = 0;
    endtask

    task automatic wr_norm(input logic [7:0] off, input logic [31:0] d, input string req);
        wr_en_n = 1; wr_addr = off; wr_data = d; tick(req);
    endtask

    task automatic wr_comp(input logic [7:0] off, input logic [31:0] d, input string req);
        wr_en_c = 1; wr_addr = off; wr_data = d; tick(req);
    endtask

    task automatic look(input logic [35:0] a, input logic c, input string req);
        addr = a; coh = c; tick(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin nb[i] = '0; ns[i] = '0; end
        for (int i = 0; i < 2; i++) cm[i] = '0;
        addr = 36'h0_0000_0000;

        // R1: outputs quiet in reset, even with a write strobe
        wr_en_n = 1; wr_en_c = 1; wr_addr = 8'h04; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "hit in reset",   n_hit, 0);
        check("R1", "c_hit in reset", c_hit, 0);
        check("R1", "attr in reset",  n_attr, 0);
        wr_en_n = 0; wr_en_c = 0;
        rst_n = 1;
        look(36'h0_0000_0000, 0, "R1");
        look(36'h0_4000_0000, 1, "R1");

        // R3/R4: program four linear windows
        wr_norm(8'h00, 32'h0000_0000, "R4");
        wr_norm(8'h04, 32'h0F00_0009, "R3");   // 256 MB, cs 2
        wr_norm(8'h08, 32'h1000_0000, "R4");
        wr_norm(8'h0C, 32'h0F00_0005, "R3");   // 256 MB, cs 1
        wr_norm(8'h10, 32'h4000_0001, "R4");   // base 0x1_4000_0000
        wr_norm(8'h14, 32'h0000_000D, "R3");   // 16 MB, cs 3
        wr_norm(8'h18, 32'h0800_0000, "R4");
        wr_norm(8'h1C, 32'h0000_0015, "R3");   // 16 MB, cs 5

        look(36'h0_0000_0000, 0, "R5");
        look(36'h0_0FFF_FFFF, 0, "R3");
        look(36'h0_1000_0000, 1, "R6");
        look(36'h0_1FFF_FFFF, 0, "R3");
        look(36'h0_2000_0000, 0, "R9");
        look(36'h0_0800_0100, 0, "R8");
        look(36'h1_4000_0000, 1, "R7");
        look(36'h1_40FF_FFFF, 0, "R4");
        look(36'h1_4100_0000, 0, "R9");
        look(36'h0_4000_0000, 0, "R4");
        look(36'h2_0000_0000, 1, "R9");

        // R2: ignored writes
        wr_norm(8'h01, 32'hFFFF_FFFF, "R2");
        wr_norm(8'h06, 32'h0000_0000, "R2");
        wr_norm(8'h22, 32'h0000_0000, "R2");
        wr_norm(8'h20, 32'h0000_0000, "R2");
        look(36'h0_0000_0004, 1, "R2");
        look(36'h0_1800_0000, 0, "R2");

        // R8: drop window 0, overlap now falls to window 3
        wr_norm(8'h04, 32'h0000_0000, "R8");
        look(36'h0_0800_0100, 1, "R8");
        look(36'h0_0000_0000, 0, "R9");

        // R10/R11: compact windows
        wr_comp(8'h00, 32'h4004_0001, "R10");  // 1 MB at 0x4000_0000
        wr_comp(8'h10, 32'h800F_0001, "R10");  // 2 GB at 0x8000_0000
        look(36'h0_4000_0000, 1, "R11");
        look(36'h0_400F_FFFF, 0, "R10");
        look(36'h0_4010_0000, 0, "R9");
        look(36'h0_8000_0000, 1, "R11");
        look(36'h0_FFFF_FFFF, 0, "R10");
        look(36'h1_0000_0000, 0, "R9");
        wr_comp(8'h08, 32'h0000_0000, "R10");
        wr_comp(8'h20, 32'h0000_0000, "R10");
        look(36'h0_4000_0000, 0, "R10");

        // R8 in compact mode: window 1 covers window 0
        wr_comp(8'h10, 32'h000F_0001, "R8");
        look(36'h0_4000_0000, 0, "R8");
        look(36'h0_4010_0000, 0, "R11");

        // R12: size field below 4
        wr_comp(8'h00, 32'h4003_0001, "R12");
        wr_comp(8'h10, 32'h0000_0000, "R12");
        look(36'h0_4000_0000, 0, "R12");
        look(36'h0_4000_0000, 1, "R12");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule